// File: doc/BRIEF.md
# Parallel ATA Multiword DMA Host Engine

This block is the host side of a multiword DMA burst on a 16-bit parallel ATA data bus. A controller loads a word count and a direction and pulses `start`. The engine then waits for the drive to raise its DMA request. Once the request is seen, it asserts the acknowledge and deselects both chip selects. It then issues a train of read or write strobes. Each strobe moves one 16-bit word. On a write the word comes from a valid/ready input stream. On a read the word goes to a one-cycle output pulse.

The engine runs from one clock, nominally 48 MHz. Every bus interval is given as a parameter in nanoseconds and rounded up to whole clock cycles, so the defaults produce the following:

| Interval | Cycles |
|---|---|
| Strobe asserted | 4 |
| Strobe negated between words | 2 (4 + 2 = 6-cycle word time) |
| Acknowledge / chip-select lead before the first strobe | 2 |
| Acknowledge hold after the last strobe | 1 |

A burst ends when the drive drops its request, when the word count is used up, or when the host-side stream cannot take or supply another word. In each case the strobe in progress is completed first.

States:
- IDLE: accepts `start`.
- WAIT_REQ: waits for `dmarq`.
- SETUP: acknowledge lead time.
- STROBE: strobe asserted.
- RECOVER: strobe negated.
- HOLD: acknowledge hold time.

Transitions:
- IDLE→WAIT_REQ on `start` with a non-zero count.
- WAIT_REQ→SETUP on `dmarq`.
- SETUP→STROBE or RECOVER→STROBE when the lead or negated time has expired and the *go* condition holds. The go condition is: request high, words left, and the stream ready (write: `in_valid`; read: `out_ready`).
- SETUP→HOLD or RECOVER→HOLD when the time has expired and go is false.
- STROBE→RECOVER after the asserted time.
- HOLD→IDLE after the hold time.

Top module: `mdma_host`

## Requirements
- R1: During and after reset, with no start, the block drives the following: `dmack_n`, `dior_n` and `diow_n` are 1; `dd_oe`, `busy`, `done`, `in_ready` and `out_valid` are 0; `cs_n` is 2'b10.
- R2: A `start` with `word_count` = 0 is ignored and `busy` stays 0. A `start` with a non-zero count raises `busy`. After such a start, `dmack_n` stays 1 and `cs_n` stays 2'b10 until `dmarq` has been sampled high on a clock edge.
- R3: A strobe is asserted only while `dmack_n` is 0. The strobe is `dior_n` when `dir_write` = 0 and `diow_n` when `dir_write` = 1. Never both, and never the other one.
- R4: Each strobe stays low at least 4 cycles. Between two strobes of one burst it stays high at least 2 cycles.
- R5: While `dmack_n` is 0, `cs_n` is 2'b11. `dmack_n` falls at least 2 cycles before the first strobe falls. `dmack_n` rises at least 1 cycle after the last strobe rises.
- R6: On a read, the word on `dd_in` during the last low cycle of `dior_n` appears on `out_data`, with `out_valid` high for one cycle. Words appear in strobe order.
- R7: On a write, one input word is taken (`in_valid` and `in_ready` high on the same edge) at each strobe start. That word is on `dd_out` with `dd_oe` = 1 while `diow_n` is low and in the sample after it rises.
- R8: On a write, no strobe starts while `in_valid` is 0. A stalled input ends the burst.
- R9: With the request held high and the stream ready, a burst moves exactly `word_count` words.
- R10: If `dmarq` falls during a strobe, that strobe completes and no further strobe is issued.
- R11: On a read, no strobe starts while `out_ready` is 0. A stalled sink ends the burst.
- R12: `done` pulses for one cycle in the cycle where `dmack_n` returns to 1 and `busy` falls, once per burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock (nominal 48 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst (sampled in IDLE) |
| dir_write | input | 1 | 1 = host writes to drive, 0 = host reads |
| word_count | input | CNT_W | Words to move in this burst |
| busy | output | 1 | Burst accepted and not yet finished |
| done | output | 1 | One-cycle pulse at burst end |
| dmarq | input | 1 | DMA request from the drive (synchronous) |
| dmack_n | output | 1 | DMA acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| cs_n | output | 2 | Chip selects, active low |
| dd_in | input | DATA_W | Data bus value from the drive |
| dd_out | output | DATA_W | Data bus value driven on writes |
| dd_oe | output | 1 | Enable for `dd_out` onto the bus |
| in_data | input | DATA_W | Write stream word |
| in_valid | input | 1 | Write stream word available |
| in_ready | output | 1 | Write stream word taken this edge |
| out_data | output | DATA_W | Read stream word |
| out_valid | output | 1 | Read stream word valid (one cycle) |
| out_ready | input | 1 | Read sink can take a word |

## Verification
The main function is tried with a set of bursts, and each one separates one cause of burst end from the others:
- Reads and writes where the count runs out show that exactly `word_count` words move.
- Bursts where the drive drops its request after one or two strobes show that the strobe in progress still completes.
- A write whose source runs dry part-way shows the input-stall exit.
- A read with the sink not ready shows that a burst can end from SETUP with no strobe at all.
- A start while the request is low shows that the acknowledge waits for the request.
- A zero-count start shows that it is ignored.

In every burst the measured pulse widths, the gaps, the acknowledge lead and hold, and the data word sequence are compared with values worked out from the nanosecond limits.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER,
        ST_HOLD
    } mdma_state_e;

    // Round a nanosecond interval up to whole clock cycles (minimum one).
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mdma_timer.sv
module mdma_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mdma_wcount.sv
module mdma_wcount #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign zero = (left_q == '0);
endmodule

// File: rtl/mdma_host.sv
module mdma_host
    import mdma_pkg::*;
#(
    parameter int DATA_W         = 16,
    parameter int CNT_W          = 16,
    parameter int CLK_MHZ        = 48,
    parameter int T_ASSERT_NS    = 80,
    parameter int T_NEGATE_NS    = 36,
    parameter int T_CYCLE_NS     = 120,
    parameter int T_DSETUP_NS    = 40,
    parameter int T_WHOLD_NS     = 18,
    parameter int T_ACK_SETUP_NS = 18,
    parameter int T_ACK_HOLD_NS  = 20,
    parameter int T_CS_SETUP_NS  = 36,
    parameter int T_CS_HOLD_NS   = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_write,
    input  logic [CNT_W-1:0]  word_count,
    output logic              busy,
    output logic              done,
    input  logic              dmarq,
    output logic              dmack_n,
    output logic              dior_n,
    output logic              diow_n,
    output logic [1:0]        cs_n,
    input  logic [DATA_W-1:0] dd_in,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    // Derived cycle counts
    localparam int ACT_CYC  = imax(ns_to_cyc(T_ASSERT_NS, CLK_MHZ),
                                   ns_to_cyc(T_DSETUP_NS, CLK_MHZ));
    localparam int NEG_CYC  = imax(ns_to_cyc(T_NEGATE_NS, CLK_MHZ),
                                   ns_to_cyc(T_CYCLE_NS, CLK_MHZ) - ACT_CYC);
    localparam int LEAD_CYC = imax(ns_to_cyc(T_ACK_SETUP_NS, CLK_MHZ),
                                   ns_to_cyc(T_CS_SETUP_NS, CLK_MHZ));
    localparam int HOLD_CYC = imax(ns_to_cyc(T_ACK_HOLD_NS, CLK_MHZ),
                                   imax(ns_to_cyc(T_WHOLD_NS, CLK_MHZ),
                                        ns_to_cyc(T_CS_HOLD_NS, CLK_MHZ)));
    localparam int MAX_CYC  = imax(imax(ACT_CYC, NEG_CYC), imax(LEAD_CYC, HOLD_CYC));
    localparam int TMR_W    = $clog2(MAX_CYC + 1);

    mdma_state_e      state_q, state_d;
    logic             dir_q;
    logic             accept;
    logic             go;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;
    logic             cnt_zero;
    logic             strobe_start;
    logic             ack_d;

    assign accept = (state_q == ST_IDLE) && start && (word_count != '0);
    assign go     = dmarq && !cnt_zero && (dir_q ? in_valid : out_ready);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept)   state_d = ST_WAIT_REQ;
            ST_WAIT_REQ: if (dmarq)    state_d = ST_SETUP;
            ST_SETUP:    if (tmr_done) state_d = go ? ST_STROBE : ST_HOLD;
            ST_STROBE:   if (tmr_done) state_d = ST_RECOVER;
            ST_RECOVER:  if (tmr_done) state_d = go ? ST_STROBE : ST_HOLD;
            ST_HOLD:     if (tmr_done) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Interval timer load
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_SETUP:   tmr_val = TMR_W'(LEAD_CYC - 1);
            ST_STROBE:  tmr_val = TMR_W'(ACT_CYC - 1);
            ST_RECOVER: tmr_val = TMR_W'(NEG_CYC - 1);
            ST_HOLD:    tmr_val = TMR_W'(HOLD_CYC - 1);
            default:    tmr_val = '0;
        endcase
    end

    assign strobe_start = tmr_load && (state_d == ST_STROBE);
    assign in_ready     = strobe_start && dir_q;
    assign ack_d        = (state_d == ST_SETUP) || (state_d == ST_STROBE) ||
                          (state_d == ST_RECOVER) || (state_d == ST_HOLD);

    mdma_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    mdma_wcount #(.W(CNT_W)) u_wcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (word_count),
        .dec      (strobe_start),
        .zero     (cnt_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) dir_q <= dir_write;
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dmack_n   <= 1'b1;
            dior_n    <= 1'b1;
            diow_n    <= 1'b1;
            cs_n      <= 2'b10;
            dd_oe     <= 1'b0;
            dd_out    <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            dmack_n   <= !ack_d;
            dior_n    <= !((state_d == ST_STROBE) && !dir_q);
            diow_n    <= !((state_d == ST_STROBE) && dir_q);
            cs_n      <= ack_d ? 2'b11 : 2'b10;
            dd_oe     <= ack_d && dir_q;
            busy      <= (state_d != ST_IDLE);
            done      <= (state_q == ST_HOLD) && tmr_done;
            out_valid <= (state_q == ST_STROBE) && tmr_done && !dir_q;
            if (in_ready) dd_out <= in_data;
            if ((state_q == ST_STROBE) && tmr_done && !dir_q) out_data <= dd_in;
        end
    end
endmodule

// File: rtl/mdma_host_sva.sv
module mdma_host_sva #(
    parameter int ACT_CYC = 4,
    parameter int NEG_CYC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       dmarq,
    input logic       dmack_n,
    input logic       dior_n,
    input logic       diow_n,
    input logic [1:0] cs_n,
    input logic       dd_oe,
    input logic       busy,
    input logic       done
);
    logic       strb;
    logic [7:0] low_cnt;
    logic [7:0] hi_cnt;
    logic       seen;

    assign strb = !dior_n || !diow_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            hi_cnt  <= '0;
            seen    <= 1'b0;
        end else begin
            low_cnt <= strb ? ((low_cnt == 8'hFF) ? low_cnt : low_cnt + 1'b1) : 8'd0;
            hi_cnt  <= strb ? 8'd0 : ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 1'b1);
            seen    <= dmack_n ? 1'b0 : (strb ? 1'b1 : seen);
        end
    end

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dmack_n) |-> $past(dmarq)); // R2
    AST_STROBE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> !dmack_n); // R3
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n)); // R3
    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb && $past(strb)) |-> (low_cnt >= 8'(ACT_CYC))); // R4
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !$past(strb) && seen) |-> (hi_cnt >= 8'(NEG_CYC))); // R4
    AST_ACK_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !$past(strb)) |-> !$past(dmack_n)); // R5
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_n) |-> !$past(strb)); // R5
    AST_CS_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !dmack_n |-> (cs_n == 2'b11)); // R5
    AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !diow_n |-> dd_oe); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dmack_n && !busy)); // R12
endmodule

bind mdma_host mdma_host_sva #(
    .ACT_CYC (ACT_CYC),
    .NEG_CYC (NEG_CYC)
) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .dmarq   (dmarq),
    .dmack_n (dmack_n),
    .dior_n  (dior_n),
    .diow_n  (diow_n),
    .cs_n    (cs_n),
    .dd_oe   (dd_oe),
    .busy    (busy),
    .done    (done)
);

// File: tb/mdma_host_bench.sv
module mdma_host_bench;
    localparam int CLK_PERIOD = 20;
    // Expected minima from the ns limits at 48 MHz: ceil(80*48/1000)=4,
    // max(ceil(36*.048), ceil(120*.048)-4)=2, lead max(1,2)=2, hold 1.
    localparam int EXP_ACT  = 4;
    localparam int EXP_NEG  = 2;
    localparam int EXP_LEAD = 2;
    localparam int EXP_HOLD = 1;

    typedef struct packed {
        logic       wr;
        logic [7:0] cnt;
        logic [7:0] dev;
        logic [7:0] src;
        logic [7:0] exp;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 8'd3, 8'd255, 8'd255, 8'd3},  // read, count ends
        '{1'b1, 8'd4, 8'd255, 8'd255, 8'd4},  // write, count ends
        '{1'b0, 8'd8, 8'd2,   8'd255, 8'd2},  // read, drive drops after 2
        '{1'b1, 8'd6, 8'd255, 8'd3,   8'd3},  // write, source stalls after 3
        '{1'b1, 8'd5, 8'd1,   8'd255, 8'd1},  // write, drive drops after 1
        '{1'b0, 8'd1, 8'd255, 8'd255, 8'd1}   // read, single word
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_write = 1'b0;
    logic [15:0] word_count = '0;
    logic        busy, done;
    logic        dmarq = 1'b0;
    logic        dmack_n, dior_n, diow_n;
    logic [1:0]  cs_n;
    logic [15:0] dd_in = '0;
    logic [15:0] dd_out;
    logic        dd_oe;
    logic [15:0] in_data;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;

    int checks = 0;
    int fails  = 0;

    int sent = 0, src_avail = 0, dev_limit = 255;
    int strobes = 0, min_low = 999, min_gap = 999, lead = -1, hold_obs = -1;
    int words_rd = 0, words_wr = 0, done_cnt = 0;
    int low_run = 0, high_run = 0, since_ack = 0, since_rise = 0;
    int bad_dir = 0, bad_cs = 0, bad_data = 0;
    logic prev_strb = 1'b0, prev_ack = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mdma_host u_mdma_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dir_write  (dir_write),
        .word_count (word_count),
        .busy       (busy),
        .done       (done),
        .dmarq      (dmarq),
        .dmack_n    (dmack_n),
        .dior_n     (dior_n),
        .diow_n     (diow_n),
        .cs_n       (cs_n),
        .dd_in      (dd_in),
        .dd_out     (dd_out),
        .dd_oe      (dd_oe),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready)
    );

    // Write source model
    assign in_valid = (sent < src_avail);
    assign in_data  = 16'h5000 + 16'(sent);
    always @(posedge clk) if (in_valid && in_ready) sent <= sent + 1;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Bus monitor and drive model, sampled away from the active edge
    always @(negedge clk) begin
        logic strb, ack;
        strb = !dior_n || !diow_n;
        ack  = !dmack_n;
        if (rst_n) begin
            if ((dir_write && !dior_n) || (!dir_write && !diow_n)) bad_dir++;
            if (ack && cs_n != 2'b11) bad_cs++;
            if (!ack && cs_n != 2'b10) bad_cs++;
            if (ack && !prev_ack) since_ack = 0;
            if (strb && !prev_strb) begin
                if (strobes == 0) lead = since_ack;
                else if (high_run < min_gap) min_gap = high_run;
                strobes++;
                low_run = 0;
                dd_in = 16'hA000 + 16'(strobes - 1);
                if (!diow_n) begin
                    checks++;
                    if (dd_out != 16'h5000 + 16'(words_wr) || !dd_oe) begin
                        fails++; bad_data++;
                        $display("FAIL R7 write word actual=%h expected=%h", dd_out,
                                 16'h5000 + 16'(words_wr));
                    end
                    words_wr++;
                end
                if (strobes == dev_limit) dmarq = 1'b0;
            end
            if (!strb && prev_strb) begin
                if (low_run < min_low) min_low = low_run;
                if (dir_write && !dd_oe) begin
                    fails++;
                    $display("FAIL R7 write hold actual=%0d expected=1", dd_oe);
                end
                high_run = 0;
                since_rise = 0;
            end
            if (!ack && prev_ack) hold_obs = since_rise;
            if (out_valid) begin
                checks++;
                if (out_data != 16'hA000 + 16'(words_rd)) begin
                    fails++; bad_data++;
                    $display("FAIL R6 read word actual=%h expected=%h", out_data,
                             16'hA000 + 16'(words_rd));
                end
                words_rd++;
            end
            if (done) done_cnt++;
            if (strb) low_run++; else high_run++;
            since_ack++;
            since_rise++;
            prev_strb = strb;
            prev_ack  = ack;
        end
    end

    task automatic clear_stats(input int src, input int dev);
        sent = 0; src_avail = src; dev_limit = dev;
        strobes = 0; min_low = 999; min_gap = 999; lead = -1; hold_obs = -1;
        words_rd = 0; words_wr = 0; bad_dir = 0; bad_cs = 0;
    endtask

    task automatic kick(input logic wr, input int cnt);
        @(negedge clk);
        dir_write = wr; word_count = 16'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        for (int i = 0; i < 600 && done_cnt == d0; i++) @(negedge clk);
    endtask

    task automatic end_checks(input int exp, input int d0, input logic wr);
        int moved;
        @(negedge clk);
        moved = wr ? words_wr : words_rd;
        check(moved == exp, "R8 R9 R10 R11 words moved", moved, exp);
        check(strobes == exp, "R3 strobe count", strobes, exp);
        check(bad_dir == 0, "R3 wrong strobe line", bad_dir, 0);
        check(bad_cs == 0, "R5 chip select level", bad_cs, 0);
        if (exp > 0) begin
            check(min_low >= EXP_ACT, "R4 asserted width", min_low, EXP_ACT);
            check(lead >= EXP_LEAD, "R5 ack lead", lead, EXP_LEAD);
            check(hold_obs >= EXP_HOLD, "R5 ack hold", hold_obs, EXP_HOLD);
        end
        if (exp > 1) check(min_gap >= EXP_NEG, "R4 negated gap", min_gap, EXP_NEG);
        check(done_cnt == d0 + 1, "R12 done pulses", done_cnt - d0, 1);
        check(busy == 1'b0 && dmack_n == 1'b1, "R12 idle after done", busy, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int d0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(dmack_n && dior_n && diow_n, "R1 strobes/ack in reset", 0, 1);
        check(cs_n == 2'b10 && !dd_oe && !busy && !done, "R1 cs/oe/busy in reset", cs_n, 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!in_ready && !out_valid && dmack_n && cs_n == 2'b10, "R1 after reset", 0, 1);

        // Table of bursts
        for (int v = 0; v < NVEC; v++) begin
            clear_stats(int'(VEC[v].src), int'(VEC[v].dev));
            d0 = done_cnt;
            @(negedge clk);
            dmarq = 1'b1;
            kick(VEC[v].wr, int'(VEC[v].cnt));
            wait_done(d0);
            dmarq = 1'b0;
            end_checks(int'(VEC[v].exp), d0, VEC[v].wr);
        end

        // R2: zero count is ignored
        clear_stats(255, 255);
        d0 = done_cnt;
        dmarq = 1'b1;
        kick(1'b0, 0);
        repeat (4) @(negedge clk);
        check(!busy && dmack_n && strobes == 0 && done_cnt == d0, "R2 zero count ignored",
              busy, 0);
        dmarq = 1'b0;

        // R2: ack waits for the request
        clear_stats(255, 255);
        d0 = done_cnt;
        kick(1'b0, 2);
        repeat (8) @(negedge clk);
        check(busy && dmack_n && cs_n == 2'b10 && strobes == 0, "R2 wait for request",
              dmack_n, 1);
        dmarq = 1'b1;
        wait_done(d0);
        dmarq = 1'b0;
        end_checks(2, d0, 1'b0);

        // R11: read with sink not ready ends without a strobe
        clear_stats(255, 255);
        d0 = done_cnt;
        out_ready = 1'b0;
        dmarq = 1'b1;
        kick(1'b0, 4);
        wait_done(d0);
        dmarq = 1'b0;
        end_checks(0, d0, 1'b0);
        out_ready = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule